// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of interrupt sources, by default thirty-two, and presents them to a processor on two request lines. One is a normal request line and one is a fast request line. Each source has its own mode word and its own handler vector, both held in a small word-addressed register space. The mode word gives a three-bit priority and a two-bit trigger selector. The trigger selector makes the source level- or edge-sensitive. For sources that the `EXT_MASK` parameter marks as external, it also picks the active polarity.

Software takes the normal interrupt by reading the normal-vector word. That read returns the handler vector of the best pending source. The read also records the source as current and pushes its priority onto a nesting stack. While the stack holds an entry, only sources of strictly greater priority can raise the normal line again. A write to the end-of-interrupt word pops one level. A read that finds no qualifying source returns a programmable spurious vector. Source 0, and any source whose fast-routing bit is set, go to the fast line instead.

All reads have a latency of one cycle. Both request lines are registered.

Top module: `vic_top`

## Requirements
- R1: A mode word (offset 4*i) keeps priority in bits 2:0 (0 lowest, 7 highest) and trigger in bits 6:5. A read of the mode word returns those fields and zero in every other bit.
- R2: Trigger codes:
  - 00: active-low level on external sources, active-high level on internal ones.
  - 01: falling edge on external sources, rising edge on internal ones.
  - 10: active-high level.
  - 11: rising edge.
  Inputs pass through a two-flop synchroniser.
- R3: The pending word (0x10C) shows the following per source:
  - A level source follows its conditioned input.
  - An edge source stays latched until it is acknowledged or cleared.
- R4: Writes to the enable word (0x120) set mask bits, and writes to the disable word (0x124) clear them. Only data bits at 1 act. The mask reads back at 0x110.
- R5: Writes to the set word (0x12C) and the clear word (0x128) set or clear the edge latch of each bit written 1. They have no effect on a level source.
- R6: A read of 0x100 returns the vector (stored at 0x80+4*i) of the enabled, pending, non-fast source with the highest priority. On equal priority the lower index wins. The read also:
  - clears that source's edge latch;
  - loads its index into bits 4:0 of the status word (0x108).
- R7: A read of 0x100 with no qualifying source returns the spurious vector (0x134) and pushes nothing.
- R8: After an acknowledge, only a source with strictly higher priority than the stack top raises the normal line. The stack never holds more than 8 entries.
- R9: A write to 0x130 pops one stack level, so sources at the previous level can request again.
- R10: Source 0, and the sources whose fast-routing bit is set, drive only the fast line:
  - 0x140 sets fast-routing bits and 0x144 clears them.
  - 0x148 reads the fast-routing bits back.
  - 0x104 reads the source 0 vector.
- R11: The core-status word (0x114) holds the fast line in bit 0 and the normal line in bit 1.
- R12: After reset the following hold:
  - Both lines are low.
  - Mask, fast-routing bits, edge latches, mode words, vectors, status and spurious vector are all zero.
  - `bus_rdata` updates in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Raw interrupt source inputs |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The checks take three things for granted about the inputs:
- `bus_rd` and `bus_wr` are never high in the same cycle.
- Offsets are word-aligned.
- A source input holds each level for several cycles, so the synchroniser sees it.

The bench keeps within these limits by driving every access through single-operation tasks that start on the falling clock edge. It keeps every source level for at least six cycles before it samples a line or reads the pending word. Random rounds draw priorities and pending sets, and they use only internal edge sources 1 to 27 with fast routing off. This keeps arbitration and nesting free of external polarity effects.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int unsigned PRIO_W = 3;
    localparam int unsigned TRIG_W = 2;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LVL_LO    = 2'b00,
        TRIG_EDGE_FALL = 2'b01,
        TRIG_LVL_HI    = 2'b10,
        TRIG_EDGE_RISE = 2'b11
    } trig_e;

    // word offsets whose values software depends on
    localparam int unsigned OFF_VEC_BASE = 32'h080;
    localparam int unsigned OFF_IVR      = 32'h100;
    localparam int unsigned OFF_FVR      = 32'h104;
    localparam int unsigned OFF_STATUS   = 32'h108;
    localparam int unsigned OFF_PEND     = 32'h10C;
    localparam int unsigned OFF_MASK     = 32'h110;
    localparam int unsigned OFF_CORE     = 32'h114;
    localparam int unsigned OFF_EN       = 32'h120;
    localparam int unsigned OFF_DIS      = 32'h124;
    localparam int unsigned OFF_CLR      = 32'h128;
    localparam int unsigned OFF_SET      = 32'h12C;
    localparam int unsigned OFF_EOI      = 32'h130;
    localparam int unsigned OFF_SPU      = 32'h134;
    localparam int unsigned OFF_FF_EN    = 32'h140;
    localparam int unsigned OFF_FF_DIS   = 32'h144;
    localparam int unsigned OFF_FF_STAT  = 32'h148;

endpackage

// File: rtl/vic_sync_edge.sv
module vic_sync_edge #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = async_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o  = st_q.s2;
    assign rise_o = st_q.s2 & ~st_q.prev;
    assign fall_o = ~st_q.s2 & st_q.prev;

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int unsigned N      = 32,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned ID_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             cand_i,
    input  logic [N-1:0][PRIO_W-1:0] prio_i,
    input  logic                     thr_valid_i,
    input  logic [PRIO_W-1:0]        thr_i,
    output logic                     hit_o,
    output logic [ID_W-1:0]          id_o,
    output logic [PRIO_W-1:0]        prio_o
);

    // descending scan with >= lets the lower index win a tie
    always_comb begin
        hit_o  = 1'b0;
        id_o   = '0;
        prio_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i] && (!thr_valid_i || prio_i[i] > thr_i) &&
                (!hit_o || prio_i[i] >= prio_o)) begin
                hit_o  = 1'b1;
                id_o   = ID_W'(i);
                prio_o = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] prio_i,
    output logic              valid_o,
    output logic [PRIO_W-1:0] top_o,
    output logic [CNT_W-1:0]  count_o
);

    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t st_d, st_q;
    logic [IDX_W-1:0] wr_idx, top_idx;

    assign wr_idx  = st_q.cnt[IDX_W-1:0];
    assign top_idx = wr_idx - 1'b1;

    always_comb begin
        st_d = st_q;
        if (push_i && st_q.cnt < CNT_W'(DEPTH)) begin
            st_d.ent[wr_idx] = prio_i;
            st_d.cnt         = st_q.cnt + 1'b1;
        end else if (pop_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = (st_q.cnt != '0);
    assign top_o   = st_q.ent[top_idx];
    assign count_o = st_q.cnt;

endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int unsigned N_SRC      = 32,
    parameter logic [31:0] EXT_MASK   = 32'hF000_0001,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned NEST_DEPTH = 8,
    localparam int unsigned PRIO_W    = vic_pkg::PRIO_W,
    localparam int unsigned ID_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int unsigned CNT_W     = $clog2(NEST_DEPTH + 1),
    localparam int unsigned MODE_W    = vic_pkg::TRIG_W + PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    import vic_pkg::*;

    typedef struct packed {
        logic [N_SRC-1:0]             mask;
        logic [N_SRC-1:0]             edge_lat;
        logic [N_SRC-1:0]             ffs;
        logic [ID_W-1:0]              cur_id;
        logic [DATA_W-1:0]            spu;
        logic [DATA_W-1:0]            rdata;
        logic                         irq;
        logic                         fiq;
        logic [N_SRC-1:0][MODE_W-1:0] mode;
        logic [N_SRC-1:0][DATA_W-1:0] vec;
    } state_t;

    state_t st_d, st_q;

    // ---------------- source conditioning ----------------
    logic [N_SRC-1:0] raw, rise, fall;
    logic [N_SRC-1:0] inv, is_edge, ev, pend, fast;
    logic [N_SRC-1:0][PRIO_W-1:0] prio;

    vic_sync_edge #(.N(N_SRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(src_in),
        .raw_o  (raw),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            trig_e t;
            t          = trig_e'(st_q.mode[i][MODE_W-1:PRIO_W]);
            prio[i]    = st_q.mode[i][PRIO_W-1:0];
            inv[i]     = EXT_MASK[i] && (t == TRIG_LVL_LO || t == TRIG_EDGE_FALL);
            is_edge[i] = (t == TRIG_EDGE_FALL || t == TRIG_EDGE_RISE);
            ev[i]      = inv[i] ? fall[i] : rise[i];
            pend[i]    = is_edge[i] ? st_q.edge_lat[i] : (raw[i] ^ inv[i]);
        end
        fast = st_q.ffs | N_SRC'(1);
    end

    // ---------------- arbitration and nesting ----------------
    logic              arb_hit;
    logic [ID_W-1:0]   arb_id;
    logic [PRIO_W-1:0] arb_prio;
    logic              stk_valid;
    logic [PRIO_W-1:0] stk_top;
    logic [CNT_W-1:0]  stk_cnt;
    logic              ack, eoi;

    vic_arbiter #(.N(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .cand_i     (pend & st_q.mask & ~fast),
        .prio_i     (prio),
        .thr_valid_i(stk_valid),
        .thr_i      (stk_top),
        .hit_o      (arb_hit),
        .id_o       (arb_id),
        .prio_o     (arb_prio)
    );

    vic_prio_stack #(.DEPTH(NEST_DEPTH), .PRIO_W(PRIO_W)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (ack),
        .pop_i  (eoi),
        .prio_i (arb_prio),
        .valid_o(stk_valid),
        .top_o  (stk_top),
        .count_o(stk_cnt)
    );

    // ---------------- address decode ----------------
    logic       aligned, in_mode, in_vec;
    logic [4:0] reg_idx;
    logic [N_SRC-1:0] wmask;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign in_mode = aligned && (bus_addr < ADDR_W'(OFF_VEC_BASE));
    assign in_vec  = aligned && (bus_addr >= ADDR_W'(OFF_VEC_BASE)) &&
                     (bus_addr < ADDR_W'(OFF_IVR));
    assign reg_idx = bus_addr[6:2];
    assign wmask   = bus_wdata[N_SRC-1:0];

    function automatic logic hit_at(input logic [ADDR_W-1:0] a, input int unsigned off);
        return a == ADDR_W'(off);
    endfunction

    assign ack = bus_rd && hit_at(bus_addr, OFF_IVR) && arb_hit &&
                 (stk_cnt < CNT_W'(NEST_DEPTH));
    assign eoi = bus_wr && hit_at(bus_addr, OFF_EOI);

    // ---------------- read mux ----------------
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (in_mode) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (reg_idx == 5'(i)) begin
                    rd_val[6:5] = st_q.mode[i][MODE_W-1:PRIO_W];
                    rd_val[2:0] = st_q.mode[i][PRIO_W-1:0];
                end
            end
        end else if (in_vec) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (reg_idx == 5'(i)) rd_val = st_q.vec[i];
            end
        end else if (hit_at(bus_addr, OFF_IVR)) begin
            rd_val = ack ? st_q.vec[arb_id] : st_q.spu;
        end else if (hit_at(bus_addr, OFF_FVR)) begin
            rd_val = st_q.vec[0];
        end else if (hit_at(bus_addr, OFF_STATUS)) begin
            rd_val[ID_W-1:0] = st_q.cur_id;
        end else if (hit_at(bus_addr, OFF_PEND)) begin
            rd_val[N_SRC-1:0] = pend;
        end else if (hit_at(bus_addr, OFF_MASK)) begin
            rd_val[N_SRC-1:0] = st_q.mask;
        end else if (hit_at(bus_addr, OFF_CORE)) begin
            rd_val[1:0] = {st_q.irq, st_q.fiq};
        end else if (hit_at(bus_addr, OFF_SPU)) begin
            rd_val = st_q.spu;
        end else if (hit_at(bus_addr, OFF_FF_STAT)) begin
            rd_val[N_SRC-1:0] = st_q.ffs;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        logic [N_SRC-1:0] e;
        st_d = st_q;

        e = st_q.edge_lat | (ev & is_edge);
        if (bus_wr && hit_at(bus_addr, OFF_SET)) e = e | wmask;
        if (bus_wr && hit_at(bus_addr, OFF_CLR)) e = e & ~wmask;
        if (ack) e[arb_id] = 1'b0;
        st_d.edge_lat = e & is_edge;

        if (bus_wr && hit_at(bus_addr, OFF_EN))     st_d.mask = st_q.mask | wmask;
        if (bus_wr && hit_at(bus_addr, OFF_DIS))    st_d.mask = st_q.mask & ~wmask;
        if (bus_wr && hit_at(bus_addr, OFF_FF_EN))  st_d.ffs  = st_q.ffs | wmask;
        if (bus_wr && hit_at(bus_addr, OFF_FF_DIS)) st_d.ffs  = st_q.ffs & ~wmask;
        if (bus_wr && hit_at(bus_addr, OFF_SPU))    st_d.spu  = bus_wdata;

        for (int i = 0; i < N_SRC; i++) begin
            if (bus_wr && in_mode && reg_idx == 5'(i))
                st_d.mode[i] = {bus_wdata[6:5], bus_wdata[2:0]};
            if (bus_wr && in_vec && reg_idx == 5'(i))
                st_d.vec[i] = bus_wdata;
        end

        if (ack)    st_d.cur_id = arb_id;
        if (bus_rd) st_d.rdata  = rd_val;

        st_d.irq = arb_hit;
        st_d.fiq = |(pend & st_q.mask & fast);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = st_q.irq;
    assign fiq_o     = st_q.fiq;

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [N_SRC-1:0]  pend,
    input logic [N_SRC-1:0]  mask,
    input logic [N_SRC-1:0]  fast,
    input logic [CNT_W-1:0]  stk_cnt,
    input logic              irq_o,
    input logic              fiq_o
);
    import vic_pkg::*;

    p_bus_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_cnt <= CNT_W'(DEPTH));

    p_eoi_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EOI) && stk_cnt != '0)
        |=> stk_cnt == $past(stk_cnt) - 1'b1);

    p_enable_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EN))
        |=> (mask & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]));

    p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_DIS))
        |=> (mask & $past(bus_wdata[N_SRC-1:0])) == '0);

    p_irq_has_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(pend & mask & ~fast)));

    p_fiq_has_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(|(pend & mask & fast)));

endmodule

bind vic_top vic_checker #(
    .N_SRC (N_SRC),
    .DEPTH (NEST_DEPTH),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pend     (pend),
    .mask     (st_q.mask),
    .fast     (fast),
    .stk_cnt  (stk_cnt),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
);

// File: tb/vic_top_bench.sv
module vic_top_bench;

    localparam logic [31:0] EXT = 32'hF000_0001;
    localparam logic [31:0] SPU = 32'h5555_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = EXT;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    vic_top u_vic_top (
        .clk(clk), .rst_n(rst_n), .src_in(src),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [31:0] vexp(input int i);
        return 32'hA000_0000 | (i << 4);
    endfunction

    function automatic int pick(input logic [31:0] c, input logic [2:0] pr[32],
                                input bit tv, input logic [2:0] t);
        int best = -1;
        for (int i = 0; i < 32; i++)
            if (c[i] && (!tv || pr[i] > t) && (best < 0 || pr[i] > pr[best])) best = i;
        return best;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [2:0]  pr[32];
        logic [2:0]  stk[8];
        int          sp;
        void'($urandom(32'd2718));

        idle(4); rst_n = 1'b1; idle(4);
        // R12 reset state
        chk("R12 irq", {31'b0, irq_o}, 0);
        chk("R12 fiq", {31'b0, fiq_o}, 0);
        rd(9'h110, d); chk("R12 mask", d, 0);
        rd(9'h10C, d); chk("R12 pend", d, 0);
        rd(9'h134, d); chk("R12 spurious", d, 0);
        rd(9'h108, d); chk("R12 status", d, 0);

        for (int i = 0; i < 32; i++) wr(9'h080 + 9'(4 * i), vexp(i));
        wr(9'h134, SPU);

        // R1 field layout
        wr(9'h00C, 32'hFFFF_FFFF);
        rd(9'h00C, d); chk("R1 mode readback", d, 32'h67);
        wr(9'h00C, 0);
        // R7 nothing pending
        rd(9'h100, d); chk("R7 spurious empty", d, SPU);

        // R2 external low level, source 30 prio 3
        wr(9'h078, 32'h03); wr(9'h120, 32'h4000_0000);
        src[30] = 1'b0; idle(6);
        chk("R2 low level irq", {31'b0, irq_o}, 1);
        chk("R10 no fiq", {31'b0, fiq_o}, 0);
        rd(9'h114, d); chk("R11 core irq", d, 2);
        rd(9'h100, d); chk("R6 vector 30", d, vexp(30));
        rd(9'h108, d); chk("R6 status 30", d, 30);
        idle(3); chk("R8 same prio blocked", {31'b0, irq_o}, 0);
        wr(9'h130, 0); idle(3);
        chk("R9 eoi reasserts", {31'b0, irq_o}, 1);
        src[30] = 1'b1; idle(6);
        chk("R3 level follows irq", {31'b0, irq_o}, 0);
        rd(9'h10C, d); chk("R3 level follows pend", d, 0);
        wr(9'h124, 32'h4000_0000);

        // R4 enable/disable act only on ones
        wr(9'h120, 32'hF0); rd(9'h110, d); chk("R4 enable", d, 32'hF0);
        wr(9'h120, 0);      rd(9'h110, d); chk("R4 enable zero", d, 32'hF0);
        wr(9'h124, 32'h30); rd(9'h110, d); chk("R4 disable", d, 32'hC0);
        wr(9'h124, 0);      rd(9'h110, d); chk("R4 disable zero", d, 32'hC0);
        wr(9'h124, 32'hFFFF_FFFF);

        // R3 external falling edge latched, source 29
        wr(9'h074, 32'h22);
        src[29] = 1'b0; idle(6); src[29] = 1'b1; idle(6);
        rd(9'h10C, d); chk("R3 fall latched", d, 32'h2000_0000);
        wr(9'h128, 32'h2000_0000);
        rd(9'h10C, d); chk("R5 clear edge", d, 0);

        // rising edge source 31 prio 6, acknowledge clears latch
        wr(9'h07C, 32'h66);
        src[31] = 1'b0; idle(6); src[31] = 1'b1; idle(6);
        rd(9'h10C, d); chk("R2 rising latched", d, 32'h8000_0000);
        wr(9'h120, 32'h8000_0000); idle(3);
        chk("R2 rising irq", {31'b0, irq_o}, 1);
        rd(9'h100, d); chk("R6 vector 31", d, vexp(31));
        idle(3);
        rd(9'h10C, d); chk("R6 ack clears edge", d, 0);
        chk("R6 irq drops", {31'b0, irq_o}, 0);
        wr(9'h130, 0); wr(9'h124, 32'hFFFF_FFFF);

        // R5 set on level source has no effect, on edge source latches
        wr(9'h12C, 32'h20); idle(2);
        rd(9'h10C, d); chk("R5 set level ignored", d, 0);
        wr(9'h01C, 32'h21); wr(9'h12C, 32'h80);
        rd(9'h10C, d); chk("R5 set edge", d, 32'h80);

        // R10 fast routing
        wr(9'h140, 32'h80); rd(9'h148, d); chk("R10 ff status", d, 32'h80);
        wr(9'h120, 32'h80); idle(3);
        chk("R10 fiq", {31'b0, fiq_o}, 1);
        chk("R10 irq quiet", {31'b0, irq_o}, 0);
        rd(9'h114, d); chk("R11 core fiq", d, 1);
        rd(9'h100, d); chk("R10 fast not on irq", d, SPU);
        rd(9'h104, d); chk("R10 fvr", d, vexp(0));
        wr(9'h128, 32'h80); wr(9'h124, 32'h80); wr(9'h144, 32'h80); idle(3);
        chk("R10 fiq off", {31'b0, fiq_o}, 0);
        rd(9'h148, d); chk("R10 ff cleared", d, 0);
        wr(9'h000, 32'h04); wr(9'h120, 32'h1);
        src[0] = 1'b0; idle(6);
        chk("R10 source0 fiq", {31'b0, fiq_o}, 1);
        chk("R10 source0 irq", {31'b0, irq_o}, 0);
        src[0] = 1'b1; wr(9'h124, 32'h1); idle(6);

        // R6 tie, R8 strict nesting
        wr(9'h024, 32'h25); wr(9'h010, 32'h25);
        wr(9'h12C, 32'h210); wr(9'h120, 32'h210);
        rd(9'h100, d); chk("R6 tie lower index", d, vexp(4));
        rd(9'h100, d); chk("R8 equal prio spurious", d, SPU);
        wr(9'h130, 0);
        rd(9'h100, d); chk("R9 after pop", d, vexp(9));
        wr(9'h130, 0);
        wr(9'h124, 32'hFFFF_FFFF); wr(9'h128, 32'hFFFF_FFFF);

        // random rounds: R6 R8 R9
        for (int r = 0; r < 24; r++) begin
            logic [31:0] set, en, cur;
            for (int i = 0; i < 32; i++) pr[i] = 3'(0);
            for (int i = 1; i < 28; i++) begin
                pr[i] = 3'($urandom_range(0, 7));
                wr(9'(4 * i), {25'b0, 2'b01, 2'b00, pr[i]});
            end
            set = $urandom & 32'h0FFF_FFFE;
            en  = $urandom & 32'h0FFF_FFFE;
            wr(9'h12C, set); wr(9'h120, en);
            cur = set & en; sp = 0;
            for (int k = 0; k < 10; k++) begin
                int w;
                w = pick(cur, pr, sp != 0, (sp != 0) ? stk[sp - 1] : 3'(0));
                rd(9'h100, d);
                if (w < 0) begin
                    chk("R7 random spurious", d, SPU);
                    break;
                end
                chk("R6 R8 random vector", d, vexp(w));
                cur[w] = 1'b0; stk[sp] = pr[w]; sp++;
            end
            idle(2);
            chk("R8 irq low at end", {31'b0, irq_o}, 0);
            repeat (8) wr(9'h130, 0);
            wr(9'h124, 32'hFFFF_FFFF); wr(9'h128, 32'hFFFF_FFFF);
        end

        finish_run();
    end

endmodule